// File: doc/BRIEF.md
# Page-Bounded Stride Stream Prefetcher

The block sits beside a cache and watches the stream of demand misses, each given as a physical cache-line address. The address space is cut into 4KiB regions of 64 lines. The upper address bits name the region and the low six bits give the line offset inside it. A small table tracks a few regions, each on its own. For each region it keeps the offset of the last reference, the stride between the last two references (a signed line count) and a saturating confidence count. The block has no notion of virtual pages.

The first reference to a region only allocates an entry. A later reference to the same region whose stride is nonzero, and either establishes the first stride or repeats the stored one, triggers a pair of prefetch candidates that run ahead along that stride. A candidate that would leave the 64-line region is dropped. Accepted candidates wait in a short FIFO that drives a valid/ready output. The demand side never stalls: when the FIFO has no room, new candidates are lost.

Top module: `stride_prefetch`

## Requirements
- R1: After reset `pf_valid` is low, and cycles without `dem_valid` never create prefetches.
- R2: A reference to a region that is not in the table allocates an entry and produces no prefetch.
- R3: A reference at offset o to a tracked region with no stride yet (or with confidence reset) produces the delta d = o - last. If d is nonzero, the candidates are o+d and then o+2d, leaving the FIFO in that order.
- R4: Each further reference whose delta equals the stored stride produces two candidates. They continue from the line after the last one already produced for that stream, so no line of a stream is requested twice. Confidence saturates at 3.
- R5: A line address is {region, offset[5:0]}. A candidate whose offset falls outside 0..63 is suppressed, and once a stream leaves its region it produces nothing more.
- R6: A reference with delta zero produces no prefetch and leaves the entry's stride, confidence and progress unchanged.
- R7: A reference with a nonzero delta that differs from the stored stride produces no prefetch. It stores the new delta as the stride with confidence zero. The next reference that matches this stride restarts the candidates at its own offset plus the stride.
- R8: The table holds 4 regions. Allocation replaces the least recently referenced entry. An evicted region behaves as untracked when seen again, and the other regions keep their state.
- R9: The FIFO holds 4 lines in order. A candidate is accepted only if the occupancy at the start of the cycle plus the candidates already accepted that cycle is below 4; a pop in the same cycle does not make room. Rejected candidates are lost, and demand tracking goes on without a stall.
- R10: The FIFO head is removed only on a cycle where `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, `pf_valid` and `pf_line` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dem_valid | input | 1 | A demand miss address is present this cycle |
| dem_line | input | ADDR_W | Physical line address of the demand miss |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_ready | input | 1 | The consumer takes the offered prefetch |
| pf_line | output | ADDR_W | Physical line address to prefetch |

## Verification
A triggering demand can push two candidates into the FIFO in the same cycle that the consumer pops the head. The interesting case is when the FIFO is close to full, because the room test then looks at the occupancy before the pop. The bench provokes this by holding `pf_ready` high through long runs of back-to-back matching demands. A cycle-level model in the bench applies the R9 acceptance rule on occupancy before the pop, and the bench compares every offered line and valid bit against that model's queue.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
  localparam int OFF_W    = 6;
  localparam int STRIDE_W = OFF_W + 1;
  localparam int POS_W    = OFF_W + 3;
  localparam int CONF_W   = 2;
  localparam logic [CONF_W-1:0] CONF_TOP = '1;

  typedef logic [OFF_W-1:0]           off_t;
  typedef logic signed [STRIDE_W-1:0] stride_t;
  typedef logic signed [POS_W-1:0]    pos_t;
  typedef logic [CONF_W-1:0]          conf_t;

  // signed line distance between two offsets of one region
  function automatic stride_t line_delta(input off_t now_off, input off_t prev_off);
    stride_t a, b;
    a = stride_t'({1'b0, now_off});
    b = stride_t'({1'b0, prev_off});
    return a - b;
  endfunction

  function automatic pos_t pos_of(input off_t o);
    return pos_t'({{(POS_W-OFF_W){1'b0}}, o});
  endfunction

  function automatic pos_t pos_step(input pos_t p, input stride_t s);
    pos_t ext;
    ext = {{(POS_W-STRIDE_W){s[STRIDE_W-1]}}, s};
    return p + ext;
  endfunction

  // a position lies in the region when no bit above the offset is set
  function automatic logic pos_inside(input pos_t p);
    return p[POS_W-1:OFF_W] == '0;
  endfunction

  function automatic conf_t conf_bump(input conf_t c);
    return (c == CONF_TOP) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/spf_table.sv
`timescale 1ns/1ps
module spf_table
  import spf_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_valid,
  input  logic [ADDR_W-1:0] dem_line,
  output logic              dem_hit,
  output logic              fire,
  output logic              cand0_ok,
  output logic [ADDR_W-1:0] cand0_line,
  output logic              cand1_ok,
  output logic [ADDR_W-1:0] cand1_line
);
  localparam int REG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              vld_q    [ENTRIES];
  logic [REG_W-1:0]  tag_q    [ENTRIES];
  off_t              last_q   [ENTRIES];
  stride_t           stride_q [ENTRIES];
  conf_t             conf_q   [ENTRIES];
  pos_t              nxt_q    [ENTRIES];
  logic [IDX_W-1:0]  age_q    [ENTRIES];

  logic [REG_W-1:0]  dem_reg;
  off_t              dem_off;
  logic [ENTRIES-1:0] match;
  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx, vic_idx, sel;
  stride_t           delta;
  logic              agree, nonzero;
  pos_t              base, c0, c1, nxt_new;
  logic              c0_in, c1_in;

  assign dem_reg = dem_line[ADDR_W-1:OFF_W];
  assign dem_off = dem_line[OFF_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = vld_q[g] && (tag_q[g] == dem_reg);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    vic_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (age_q[i] == IDX_W'(ENTRIES-1)) vic_idx = IDX_W'(i);
    end
  end

  assign sel     = hit_any ? hit_idx : vic_idx;
  assign delta   = line_delta(dem_off, last_q[sel]);
  assign nonzero = (delta != '0);
  assign agree   = (stride_q[sel] == '0) || (delta == stride_q[sel]);
  assign fire    = dem_valid && hit_any && nonzero && agree;
  assign dem_hit = hit_any;

  assign base    = (conf_q[sel] == '0) ? pos_step(pos_of(dem_off), delta) : nxt_q[sel];
  assign c0      = base;
  assign c1      = pos_step(base, delta);
  assign c0_in   = pos_inside(c0);
  assign c1_in   = pos_inside(c1);
  assign nxt_new = !c0_in ? c0 : (!c1_in ? c1 : pos_step(c1, delta));

  assign cand0_ok   = fire && c0_in;
  assign cand1_ok   = cand0_ok && c1_in;
  assign cand0_line = {dem_reg, c0[OFF_W-1:0]};
  assign cand1_line = {dem_reg, c1[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i]    <= 1'b0;
        tag_q[i]    <= '0;
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        conf_q[i]   <= '0;
        nxt_q[i]    <= '0;
        age_q[i]    <= IDX_W'(i);
      end
    end else if (dem_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == sel) age_q[i] <= '0;
        else if (age_q[i] < age_q[sel]) age_q[i] <= age_q[i] + 1'b1;
      end
      if (!hit_any) begin
        vld_q[sel]    <= 1'b1;
        tag_q[sel]    <= dem_reg;
        last_q[sel]   <= dem_off;
        stride_q[sel] <= '0;
        conf_q[sel]   <= '0;
        nxt_q[sel]    <= '0;
      end else if (nonzero) begin
        last_q[sel]   <= dem_off;
        stride_q[sel] <= delta;
        if (agree) begin
          conf_q[sel] <= conf_bump(conf_q[sel]);
          nxt_q[sel]  <= nxt_new;
        end else begin
          conf_q[sel] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spf_fifo.sv
`timescale 1ns/1ps
module spf_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in0_v,
  input  logic [W-1:0]     in0_d,
  input  logic             in1_v,
  input  logic [W-1:0]     in1_d,
  output logic             out_v,
  input  logic             out_rdy,
  output logic [W-1:0]     out_d,
  output logic             acc0,
  output logic             acc1,
  output logic [CNT_W-1:0] cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign acc0  = in0_v && (cnt_q < CNT_W'(DEPTH));
  assign acc1  = in1_v && ((cnt_q + CNT_W'(acc0)) < CNT_W'(DEPTH));
  assign out_v = (cnt_q != '0);
  assign out_d = mem[rd_q];
  assign pop   = out_v && out_rdy;
  assign cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (acc0) mem[wr_q] <= in0_d;
    if (acc1) mem[wrap(wr_q, int'(acc0))] <= in1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wrap(wr_q, int'(acc0) + int'(acc1));
      rd_q  <= wrap(rd_q, int'(pop));
      cnt_q <= cnt_q + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/stride_prefetch.sv
`timescale 1ns/1ps
module stride_prefetch #(
  parameter int ADDR_W     = 20,
  parameter int ENTRIES    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_valid,
  input  logic [ADDR_W-1:0] dem_line,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_line
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 2);

  // named internal events, observed by the bound checker
  logic              dem_hit;
  logic              pf_fire;
  logic              cand0_ok, cand1_ok;
  logic [ADDR_W-1:0] cand0_line, cand1_line;
  logic              take0, take1;
  logic [CNT_W-1:0]  fifo_cnt;

  spf_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .dem_valid (dem_valid),
    .dem_line  (dem_line),
    .dem_hit   (dem_hit),
    .fire      (pf_fire),
    .cand0_ok  (cand0_ok),
    .cand0_line(cand0_line),
    .cand1_ok  (cand1_ok),
    .cand1_line(cand1_line)
  );

  spf_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .in0_v  (cand0_ok),
    .in0_d  (cand0_line),
    .in1_v  (cand1_ok),
    .in1_d  (cand1_line),
    .out_v  (pf_valid),
    .out_rdy(pf_ready),
    .out_d  (pf_line),
    .acc0   (take0),
    .acc1   (take1),
    .cnt    (fifo_cnt)
  );
endmodule

// File: rtl/spf_checks.sv
`timescale 1ns/1ps
module spf_checks
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dem_valid,
  input logic [ADDR_W-1:0] dem_line,
  input logic              dem_hit,
  input logic              pf_fire,
  input logic              cand0_ok,
  input logic [ADDR_W-1:0] cand0_line,
  input logic              cand1_ok,
  input logic [ADDR_W-1:0] cand1_line,
  input logic              take0,
  input logic              take1,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_line
);
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !dem_valid |-> (!cand0_ok && !cand1_ok && !pf_fire));

  a_r2_first_ref_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_valid && !dem_hit) |-> (!cand0_ok && !pf_fire));

  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    cand1_ok |-> cand0_ok);

  a_r5_cand0_region: assert property (@(posedge clk) disable iff (!rst_n)
    cand0_ok |-> (cand0_line[ADDR_W-1:OFF_W] == dem_line[ADDR_W-1:OFF_W]));

  a_r5_cand1_region: assert property (@(posedge clk) disable iff (!rst_n)
    cand1_ok |-> (cand1_line[ADDR_W-1:OFF_W] == dem_line[ADDR_W-1:OFF_W]));

  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(FIFO_DEPTH)) |-> (!take0 && !take1));

  a_r10_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !take0 && !take1) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));
endmodule

bind stride_prefetch spf_checks #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) i_spf_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .dem_valid (dem_valid),
  .dem_line  (dem_line),
  .dem_hit   (dem_hit),
  .pf_fire   (pf_fire),
  .cand0_ok  (cand0_ok),
  .cand0_line(cand0_line),
  .cand1_ok  (cand1_ok),
  .cand1_line(cand1_line),
  .take0     (take0),
  .take1     (take1),
  .fifo_cnt  (fifo_cnt),
  .pf_valid  (pf_valid),
  .pf_ready  (pf_ready),
  .pf_line   (pf_line)
);

// File: tb/test_stride_prefetch.sv
`timescale 1ns/1ps
module test_stride_prefetch;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dem_valid = 1'b0;
  logic [AW-1:0] dem_line = '0;
  logic          pf_ready = 1'b0;
  logic          pf_valid;
  logic [AW-1:0] pf_line;

  always #2.5 clk = ~clk;

  stride_prefetch #(.ADDR_W(AW), .ENTRIES(4), .FIFO_DEPTH(4)) i_stride_prefetch (
    .clk(clk), .rst_n(rst_n), .dem_valid(dem_valid), .dem_line(dem_line),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  expq[$];
  int  rgn = 1;

  // reference model of the tracking table, written from the requirements
  bit  m_v    [4];
  int  m_tag  [4];
  int  m_last [4];
  int  m_str  [4];
  int  m_conf [4];
  int  m_nxt  [4];
  int  m_lru[$];

  function automatic void touch(int slot);
    for (int k = 0; k < m_lru.size(); k++)
      if (m_lru[k] == slot) begin m_lru.delete(k); break; end
    m_lru.push_front(slot);
  endfunction

  function automatic void model_demand(int line, output int n, output int l0, output int l1);
    int r, off, h, d, pos;
    int got[2];
    r = line / 64; off = line % 64; h = -1; n = 0;
    got[0] = 0; got[1] = 0;
    for (int k = 0; k < 4; k++) if (m_v[k] && m_tag[k] == r) h = k;
    if (h < 0) begin
      h = -1;
      for (int k = 3; k >= 0; k--) if (!m_v[k]) h = k;
      if (h < 0) h = m_lru[m_lru.size()-1];
      m_v[h] = 1'b1; m_tag[h] = r; m_last[h] = off;
      m_str[h] = 0; m_conf[h] = 0; m_nxt[h] = 0;
      touch(h);
    end else begin
      touch(h);
      d = off - m_last[h];
      if (d != 0) begin
        m_last[h] = off;
        if (m_str[h] == 0 || d == m_str[h]) begin
          pos = (m_conf[h] == 0) ? off + d : m_nxt[h];
          for (int k = 0; k < 2; k++)
            if (pos >= 0 && pos <= 63) begin got[n] = r * 64 + pos; n++; pos += d; end
          m_nxt[h] = pos; m_str[h] = d;
          m_conf[h] = (m_conf[h] >= 3) ? 3 : m_conf[h] + 1;
        end else begin
          m_str[h] = d; m_conf[h] = 0;
        end
      end
    end
    l0 = got[0]; l1 = got[1];
  endfunction

  task automatic check_val(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare outputs, then advance the model as the edge will
  task automatic step(bit dv, int line, bit rdy, string tag);
    int n, l0, l1, room;
    int cand[2];
    int newq[$];
    bit pop;
    @(negedge clk);
    dem_valid = dv; dem_line = AW'(line); pf_ready = rdy;
    #1;
    check_val(tag, "pf_valid", int'(pf_valid), (expq.size() != 0) ? 1 : 0);
    if (pf_valid && expq.size() != 0) check_val(tag, "pf_line", int'(pf_line), expq[0]);
    room = expq.size();
    pop  = rdy && (room > 0);
    n = 0; l0 = 0; l1 = 0;
    if (dv) model_demand(line, n, l0, l1);
    cand[0] = l0; cand[1] = l1;
    for (int k = 0; k < n; k++)
      if (room < 4) begin newq.push_back(cand[k]); room++; end
    if (pop) void'(expq.pop_front());
    foreach (newq[k]) expq.push_back(newq[k]);
    @(posedge clk);
  endtask

  task automatic drain(string tag);
    while (expq.size() != 0) step(1'b0, 0, 1'b1, tag);
    step(1'b0, 0, 1'b0, tag);
  endtask

  task automatic dem(int r, int off, string tag);
    step(1'b1, r * 64 + off, 1'b0, tag);
    drain(tag);
  endtask

  initial begin
    int pos, ra, rb, rc, rd, re;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check_val("R1", "pf_valid in reset", int'(pf_valid), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 0, 1'b0, "R1");

    // R2 R3 R4 R5: sweep every nonzero stride from several start offsets
    for (int s = -63; s <= 63; s++) begin
      if (s == 0) continue;
      for (int st = 0; st < 4; st++) begin
        pos = (st == 0) ? 0 : (st == 1) ? 17 : (st == 2) ? 40 : 63;
        dem(rgn, pos, "R2");
        pos += s;
        if (pos >= 0 && pos <= 63) begin
          dem(rgn, pos, "R3");
          pos += s;
        end
        while (pos >= 0 && pos <= 63) begin
          dem(rgn, pos, "R5");
          pos += s;
        end
        rgn++;
      end
    end

    // R6: zero delta is ignored
    dem(rgn, 20, "R6"); dem(rgn, 20, "R6"); dem(rgn, 20, "R6"); dem(rgn, 23, "R6");
    dem(rgn, 23, "R6"); dem(rgn, 26, "R6");
    rgn++;

    // R7: stride change retrains
    dem(rgn, 10, "R7"); dem(rgn, 12, "R7"); dem(rgn, 15, "R7");
    dem(rgn, 18, "R7"); dem(rgn, 21, "R7"); dem(rgn, 19, "R7"); dem(rgn, 17, "R7");
    rgn++;

    // R8: four regions, least recently used replaced
    ra = rgn; rb = rgn + 1; rc = rgn + 2; rd = rgn + 3; re = rgn + 4; rgn += 5;
    dem(ra, 5, "R8"); dem(rb, 5, "R8"); dem(rc, 5, "R8"); dem(rd, 5, "R8");
    dem(ra, 7, "R8");
    dem(re, 5, "R8");
    dem(rb, 9, "R8");
    dem(rd, 8, "R8");
    dem(ra, 9, "R8");
    dem(re, 4, "R8");

    // R9: FIFO full drops, demand tracking continues
    for (int k = 0; k < 10; k++) step(1'b1, rgn * 64 + k, 1'b0, "R9");
    drain("R9");
    dem(rgn, 10, "R9"); dem(rgn, 11, "R9");
    rgn++;

    // R10: head held while not ready
    dem(rgn, 30, "R10");
    step(1'b1, rgn * 64 + 32, 1'b0, "R10");
    repeat (4) step(1'b0, 0, 1'b0, "R10");
    drain("R10");
    rgn++;

    // R9 with pops in the same cycles as pushes
    for (int k = 1; k <= 61; k += 3) step(1'b1, rgn * 64 + k, 1'b1, "R9");
    drain("R9");
    rgn++;
    for (int k = 63; k >= 0; k--) step(1'b1, rgn * 64 + k, 1'b1, "R4");
    drain("R4");
    rgn++;
    for (int k = 0; k < 30; k++) step(1'b1, rgn * 64 + k, (k % 2) == 0, "R9");
    drain("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule